// File: doc/BRIEF.md
# Reordered Subsection Triangular Spread Modulator

This block produces the offset that a clock generator's code logic adds to, or subtracts from, a stored centre oscillator code in order to spread the output spectrum. One triangular modulation period is split into COUNT subsections. A new subsection starts on each pulse of the subsection tick. The block reports the offset of the current subsection as a direction flag and a 16-bit magnitude. The magnitude is always a whole multiple of the spreading step S.

The subsections do not follow the plain rising and falling triangle. They are replayed in groups of four. Each group holds two offsets and their negatives, so the offset sums to zero at the end of every group. A one-cycle strobe marks each group end, which is the point where the outer loop may safely run its phase correction. Within a group, a large offset is paired with a small one. This keeps every jump between neighbouring subsections at or below COUNT/4 steps, which is within the bound of COUNT/4+1 steps. The set of levels visited in one period is still that of an ordinary triangle.

The section and step selectors are captured only while the modulator is idle. A running period therefore never changes shape part-way through.

Top module: `tri_spread_mod`

## Requirements
- R1: While reset is asserted, and in every cycle after a rising clock edge that sampled `spread_en` low, `step_mag` is 0, `dir_sub` is 0 (add) and `maint_pulse` is 0.
- R2: `sect_sel` values 0, 1, 2 and 3 select COUNT = 8, 16, 32 and 64. Any other value selects 16. The subsection index runs from 0 to COUNT-1 and then returns to 0, so the sequence repeats after COUNT ticks.
- R3: `step_sel` value k selects the spreading step S = 2^k (k = 0..7). The largest magnitude in a period is (COUNT/4)·S.
- R4: Let Q = COUNT/4, and for subsection index i let g = i/4 and p = i mod 4. The signed offset is +g·S for p=0, −(Q−g)·S for p=1, −g·S for p=2 and +(Q−g)·S for p=3. `dir_sub` is 1 exactly when the offset is negative, and `step_mag` is its absolute value.
- R5: No two consecutive outputs differ by more than (COUNT/4+1)·S. This includes the wrap from the last subsection to the first, so the bound is 5S for COUNT=16 and 9S for COUNT=32.
- R6: The four offsets of each group (indices 4g..4g+3) sum to zero, so the offsets of a whole period sum to zero.
- R7: In one period, the offset levels in units of S are visited as follows: 0 twice, +Q and −Q once each, and every other level from −(Q−1) to +(Q−1) twice.
- R8: `maint_pulse` is high for exactly one cycle after a rising edge that sampled `sub_tick` high while the index was at the last subsection of a group (p=3). This gives COUNT/4 pulses per period.
- R9: `sect_sel` and `step_sel` are captured at each rising edge where the modulator was idle. Changes made while it runs have no effect until it is disabled and enabled again.
- R10: On the first rising edge that samples `spread_en` high, the index starts at 0 and a tick on that same edge is ignored. A tick sampled on a later edge advances the index, and the new offset is visible after that edge. Without a tick, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spread_en | input | 1 | Run the modulation; low forces the offset to zero |
| sect_sel | input | 3 | Subsection count selector |
| step_sel | input | 3 | Spreading step selector (S = 2^k) |
| sub_tick | input | 1 | Advance to the next subsection |
| dir_sub | output | 1 | 1 = subtract the magnitude, 0 = add |
| step_mag | output | 16 | Offset magnitude in code units |
| maint_pulse | output | 1 | One-cycle strobe at each zero-sum group end |

## Verification
Every result is due one rising edge after the input that causes it:
- A tick sampled at an edge shows its new offset right after that edge.
- The group-end strobe rises at the same edge as that offset.
- Enabling or disabling takes effect at the first edge that samples the new level.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge. The outputs are compared against that model on the following falling edge, so every comparison lands half a period after the edge that was expected to change them. Whole-period sweeps also collect one offset per tick. They then check the jump bound, the zero sum of each group, the level counts and the strobe count for each subsection count.

// File: rtl/tsm_pkg.sv
// Shared definitions for the reordered triangular spread modulator.
// Assumes groups of exactly four subsections; the phase order is behaviour.
package tsm_pkg;

    // Position inside a four-subsection group; the order defines the schedule.
    typedef enum logic [1:0] {
        PH_UP_NEAR = 2'd0,   // +g
        PH_DN_FAR  = 2'd1,   // -(Q-g)
        PH_DN_NEAR = 2'd2,   // -g
        PH_UP_FAR  = 2'd3    // +(Q-g)
    } grp_phase_e;

endpackage

// File: rtl/tsm_cfg_decode.sv
// Decodes the section and step selectors into a quarter-count exponent and
// a step exponent. Assumes selectors are static while they are captured.
module tsm_cfg_decode #(
    parameter int SEL_W    = 3,
    parameter int QLOG_W   = 3,
    parameter int MAX_QLOG = 4,
    parameter int DEF_QLOG = 2
) (
    input  logic [SEL_W-1:0]  sect_sel,
    input  logic [SEL_W-1:0]  step_sel,
    output logic [QLOG_W-1:0] qlog,
    output logic [SEL_W-1:0]  stepk
);

    // Map selector n to Q = 2^(n+1); out-of-range values use the default.
    always_comb begin
        if (int'(sect_sel) < MAX_QLOG) begin
            qlog = QLOG_W'(int'(sect_sel) + 1);
        end else begin
            qlog = QLOG_W'(DEF_QLOG);
        end
        stepk = step_sel;
    end

endmodule

// File: rtl/tsm_sequencer.sv
// Subsection index counter with group-end strobe. The index is held at 0
// while idle and on the first enabled edge; it wraps at 4*2^qlog - 1.
module tsm_sequencer #(
    parameter int IDX_W  = 6,
    parameter int QLOG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [QLOG_W-1:0] qlog,
    output logic              run_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              maint_q
);

    logic [IDX_W:0]   n_sub;
    logic [IDX_W-1:0] last_idx;
    logic             grp_end;

    // Last index of the period and end-of-group detection.
    always_comb begin
        n_sub    = (IDX_W+1)'(4) << qlog;
        last_idx = IDX_W'(n_sub - 1'b1);
        grp_end  = (idx_q[1:0] == 2'b11);
    end

    // Run flag, index advance and maintenance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            idx_q   <= '0;
            maint_q <= 1'b0;
        end else begin
            run_q   <= en;
            maint_q <= run_q && en && tick && grp_end;
            if (!en || !run_q) begin
                idx_q <= '0;
            end else if (tick) begin
                idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsm_level_map.sv
// Maps the subsection index to a signed offset in the reordered schedule:
// group g plays +g, -(Q-g), -g, +(Q-g). Assumes idx < 4*Q.
module tsm_level_map #(
    parameter int IDX_W  = 6,
    parameter int QLOG_W = 3,
    parameter int SEL_W  = 3,
    parameter int STEP_W = 16
) (
    input  logic              run,
    input  logic [IDX_W-1:0]  idx,
    input  logic [QLOG_W-1:0] qlog,
    input  logic [SEL_W-1:0]  stepk,
    output logic              dir_sub,
    output logic [STEP_W-1:0] step_mag
);
    import tsm_pkg::*;

    localparam int GW = IDX_W - 2;

    logic [GW-1:0] grp;
    logic [GW:0]   quarter;
    logic [GW:0]   comp;
    logic [GW:0]   mag;
    logic          neg;
    grp_phase_e    ph;

    // Level magnitude and sign for the current group position.
    always_comb begin
        grp     = idx[IDX_W-1:2];
        ph      = grp_phase_e'(idx[1:0]);
        quarter = (GW+1)'(1) << qlog;
        comp    = quarter - {1'b0, grp};
        unique case (ph)
            PH_UP_NEAR: begin mag = {1'b0, grp}; neg = 1'b0;        end
            PH_DN_FAR:  begin mag = comp;        neg = 1'b1;        end
            PH_DN_NEAR: begin mag = {1'b0, grp}; neg = (grp != '0); end
            default:    begin mag = comp;        neg = 1'b0;        end
        endcase
        if (!run) begin
            mag = '0;
            neg = 1'b0;
        end
        dir_sub  = neg;
        step_mag = STEP_W'(mag) << stepk;
    end

endmodule

// File: rtl/tri_spread_mod.sv
// Top of the reordered triangular spread modulator. Captures the selectors
// while idle, sequences subsections on ticks and emits offset and strobe.
// Assumes the tick is synchronous to clk.
module tri_spread_mod #(
    parameter int SEL_W    = 3,
    parameter int STEP_W   = 16,
    parameter int MAX_QLOG = 4,
    parameter int DEF_QLOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en,
    input  logic [SEL_W-1:0]  sect_sel,
    input  logic [SEL_W-1:0]  step_sel,
    input  logic              sub_tick,
    output logic              dir_sub,
    output logic [STEP_W-1:0] step_mag,
    output logic              maint_pulse
);

    localparam int QLOG_W = $clog2(MAX_QLOG + 1);
    localparam int IDX_W  = MAX_QLOG + 2;

    logic [QLOG_W-1:0] dec_qlog;
    logic [SEL_W-1:0]  dec_stepk;
    logic [QLOG_W-1:0] cfg_qlog;
    logic [SEL_W-1:0]  cfg_stepk;
    logic              run_q;
    logic [IDX_W-1:0]  idx_q;

    tsm_cfg_decode #(
        .SEL_W(SEL_W), .QLOG_W(QLOG_W), .MAX_QLOG(MAX_QLOG), .DEF_QLOG(DEF_QLOG)
    ) u_dec (
        .sect_sel(sect_sel),
        .step_sel(step_sel),
        .qlog    (dec_qlog),
        .stepk   (dec_stepk)
    );

    // Capture the decoded configuration whenever the modulator was idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_qlog  <= QLOG_W'(DEF_QLOG);
            cfg_stepk <= '0;
        end else if (!run_q) begin
            cfg_qlog  <= dec_qlog;
            cfg_stepk <= dec_stepk;
        end
    end

    tsm_sequencer #(.IDX_W(IDX_W), .QLOG_W(QLOG_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (spread_en),
        .tick   (sub_tick),
        .qlog   (cfg_qlog),
        .run_q  (run_q),
        .idx_q  (idx_q),
        .maint_q(maint_pulse)
    );

    tsm_level_map #(
        .IDX_W(IDX_W), .QLOG_W(QLOG_W), .SEL_W(SEL_W), .STEP_W(STEP_W)
    ) u_map (
        .run     (run_q),
        .idx     (idx_q),
        .qlog    (cfg_qlog),
        .stepk   (cfg_stepk),
        .dir_sub (dir_sub),
        .step_mag(step_mag)
    );

endmodule

// File: rtl/tsm_chk.sv
// Property checker for tri_spread_mod, attached by bind. Observes ports and
// the captured configuration.
module tsm_chk #(
    parameter int SEL_W  = 3,
    parameter int STEP_W = 16,
    parameter int QLOG_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spread_en,
    input logic              sub_tick,
    input logic              dir_sub,
    input logic [STEP_W-1:0] step_mag,
    input logic              maint_pulse,
    input logic [QLOG_W-1:0] qlog,
    input logic [SEL_W-1:0]  stepk
);

    int off_now;
    int bound;

    // Signed offset and the allowed jump (Q+1)*S.
    always_comb begin
        off_now = dir_sub ? -int'(step_mag) : int'(step_mag);
        bound   = ((1 << qlog) + 1) << stepk;
    end

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(spread_en) |-> (step_mag == '0 && !dir_sub && !maint_pulse));

    assert_jump_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((off_now - $past(off_now)) <= bound) && (($past(off_now) - off_now) <= bound));

    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        maint_pulse |-> ($past(sub_tick) && $past(spread_en)));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        maint_pulse |=> !maint_pulse);

    assert_hold_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && !sub_tick && $past(spread_en)) |=> ($stable(step_mag) && $stable(dir_sub)));

endmodule

bind tri_spread_mod tsm_chk #(.SEL_W(SEL_W), .STEP_W(STEP_W), .QLOG_W(QLOG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spread_en  (spread_en),
    .sub_tick   (sub_tick),
    .dir_sub    (dir_sub),
    .step_mag   (step_mag),
    .maint_pulse(maint_pulse),
    .qlog       (cfg_qlog),
    .stepk      (cfg_stepk)
);

// File: tb/sim_tri_spread_mod.sv
`timescale 1ns/1ps
module sim_tri_spread_mod;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spread_en = 1'b0;
    logic [2:0]  sect_sel = 3'd1;
    logic [2:0]  step_sel = 3'd0;
    logic        sub_tick = 1'b0;
    logic        dir_sub;
    logic [15:0] step_mag;
    logic        maint_pulse;

    always #4 clk = ~clk;

    tri_spread_mod u0 (
        .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .sect_sel(sect_sel),
        .step_sel(step_sel), .sub_tick(sub_tick), .dir_sub(dir_sub),
        .step_mag(step_mag), .maint_pulse(maint_pulse)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string req_tag = "R1";
    int    cyc = 0;

    // Reference model state
    bit m_run = 1'b0;
    int m_idx = 0;
    int m_cnt = 16;
    int m_k = 0;
    bit m_maint = 1'b0;

    function automatic int dec_count(input logic [2:0] s);
        case (s)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 64;
            default: return 16;
        endcase
    endfunction

    function automatic int exp_off();
        int g, p, q, lv;
        if (!m_run) return 0;
        g = m_idx / 4; p = m_idx % 4; q = m_cnt / 4;
        case (p)
            0: lv = g;
            1: lv = -(q - g);
            2: lv = -g;
            default: lv = q - g;
        endcase
        return lv * (1 << m_k);
    endfunction

    function automatic int obs_off();
        return dir_sub ? -int'(step_mag) : int'(step_mag);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 1'b0; m_idx = 0; m_cnt = 16; m_k = 0; m_maint = 1'b0;
        end else begin
            m_maint = m_run && spread_en && sub_tick && (m_idx % 4 == 3);
            if (!m_run) begin
                m_cnt = dec_count(sect_sel);
                m_k   = int'(step_sel);
            end
            if (!spread_en || !m_run) m_idx = 0;
            else if (sub_tick) m_idx = (m_idx + 1) % m_cnt;
            m_run = spread_en;
        end
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Every-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            int e;
            e = exp_off();
            chk((step_mag == 16'(e < 0 ? -e : e)) && (dir_sub == (e < 0)),
                (!rst_n) ? "R1" : req_tag, "offset", obs_off(), e);
            chk(maint_pulse == m_maint, (!rst_n) ? "R1" : "R8", "maint_pulse",
                int'(maint_pulse), int'(m_maint));
        end
    end

    // One full period with ticks every (gap+1) cycles; checks R2,R3,R5,R6,R7,R8
    task automatic sweep(input logic [2:0] ss, input logic [2:0] ks, input int gap);
        int cnt, s, q, strobes, maxjump, badgrp, badlvl, maxmag;
        int offs[$];
        int hist[int];
        cnt = dec_count(ss); s = 1 << ks; q = cnt / 4; strobes = 0;
        req_tag = "R4";
        @(negedge clk); spread_en = 1'b0; sub_tick = 1'b0;
        @(negedge clk); sect_sel = ss; step_sel = ks; spread_en = 1'b1;
        @(negedge clk); offs.push_back(obs_off());
        for (int i = 0; i < cnt; i++) begin
            sub_tick = 1'b1;
            @(negedge clk);
            sub_tick = 1'b0;
            if (maint_pulse) strobes++;
            offs.push_back(obs_off());
            for (int j = 0; j < gap; j++) @(negedge clk);
        end
        chk(offs[0] == 0 && offs[cnt] == offs[0], "R2", "period wrap", offs[cnt], offs[0]);
        maxjump = 0; maxmag = 0;
        for (int i = 0; i < cnt; i++) begin
            int d;
            d = offs[i+1] - offs[i];
            if (d < 0) d = -d;
            if (d > maxjump) maxjump = d;
            if (offs[i] > maxmag) maxmag = offs[i];
            if (-offs[i] > maxmag) maxmag = -offs[i];
        end
        chk(maxjump <= (q + 1) * s, "R5", "largest jump", maxjump, (q + 1) * s);
        chk(maxmag == q * s, "R3", "largest magnitude", maxmag, q * s);
        badgrp = 0;
        for (int g = 0; g < q; g++) begin
            if (offs[4*g] + offs[4*g+1] + offs[4*g+2] + offs[4*g+3] != 0) badgrp++;
        end
        chk(badgrp == 0, "R6", "groups with nonzero sum", badgrp, 0);
        for (int i = 0; i < cnt; i++) hist[offs[i] / s] = hist.exists(offs[i] / s) ? hist[offs[i] / s] + 1 : 1;
        badlvl = 0;
        for (int lv = -q; lv <= q; lv++) begin
            int want, got;
            want = (lv == q || lv == -q) ? 1 : 2;
            got = hist.exists(lv) ? hist[lv] : 0;
            if (got != want) badlvl++;
        end
        chk(badlvl == 0 && hist.num() == 2 * q + 1, "R7", "level histogram mismatches", badlvl, 0);
        chk(strobes == q, "R8", "strobes per period", strobes, q);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(step_mag == 16'd0 && !dir_sub && !maint_pulse, "R1", "reset outputs",
            int'(step_mag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        sweep(3'd0, 3'd0, 0);
        sweep(3'd1, 3'd2, 1);
        sweep(3'd2, 3'd7, 0);
        sweep(3'd3, 3'd3, 0);
        sweep(3'd5, 3'd1, 2);

        // R10: tick on the enabling edge is ignored; outputs hold without tick
        req_tag = "R10";
        @(negedge clk); spread_en = 1'b0;
        @(negedge clk); sect_sel = 3'd1; step_sel = 3'd1; spread_en = 1'b1; sub_tick = 1'b1;
        @(negedge clk); sub_tick = 1'b0;
        chk(step_mag == 16'd0 && !dir_sub, "R10", "index after enabling tick", obs_off(), 0);
        sub_tick = 1'b1;
        @(negedge clk); sub_tick = 1'b0;
        chk(obs_off() == -8, "R10", "first advance", obs_off(), -8);
        repeat (3) @(negedge clk);
        chk(obs_off() == -8, "R10", "hold without tick", obs_off(), -8);

        // R9: selector changes while running are ignored
        req_tag = "R9";
        sect_sel = 3'd3; step_sel = 3'd5;
        for (int i = 0; i < 15; i++) begin
            sub_tick = 1'b1; @(negedge clk); sub_tick = 1'b0;
        end
        chk(obs_off() == 0, "R9", "wrap keeps captured count 16", obs_off(), 0);
        sub_tick = 1'b1; @(negedge clk); sub_tick = 1'b0;
        chk(obs_off() == -8, "R9", "step kept at captured S=2", obs_off(), -8);

        // R1: disabling clears outputs after one edge
        spread_en = 1'b0;
        @(negedge clk);
        chk(step_mag == 16'd0 && !dir_sub, "R1", "disabled offset", obs_off(), 0);

        // Mixed stimulus compared against the model every cycle
        req_tag = "R4";
        spread_en = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom % 64 == 0) spread_en = ~spread_en;
            sub_tick = ($urandom % 3 == 0);
            if ($urandom % 40 == 0) begin
                sect_sel = 3'($urandom);
                step_sel = 3'($urandom);
            end
        end
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule